// File: doc/BRIEF.md
# Two-Phase Strap Pin Decoder

This block classifies how one configuration pin is tied at board level, using only a digital input buffer and two switchable weak pulls. After reset it reads the pin once with both pulls disengaged to get the upper bit. It then engages the pull that opposes that first reading and reads the pin again to get the lower bit. A hard short to a rail holds its level against the opposing pull. A resistor to a rail gives way to it. One pin can therefore encode four board options.

The sequence runs once per reset. The 2-bit strap code and a derived 2-bit frequency-select index are frozen when `done` rises and stay frozen until the next reset. A configurable wait comes before each read, and the synchronizer latency is added to it inside the block. The same block is instantiated once for each strap pin. A parameter chooses whether detection begins on reset release or on a start pulse.

Top module: `strap_decoder`

## Requirements
- R1: While reset is high and on the first cycle after it, `done` is 0, both pull enables are 0, `strap_code` is 00 and `freq_sel` equals `DEFAULT_SEL`.
- R2: With `AUTO_START`=1, `done` first reads 1 after exactly `SETTLE_HI_CYC + SETTLE_LO_CYC + 2*SYNC_STAGES + 3` rising edges following reset release.
- R3: The upper bit (`strap_code[1]`) is the pin level read while both pulls are off. Both enables stay 0 for the first `SETTLE_HI_CYC + SYNC_STAGES + 1` cycles. If the upper bit is 0, only `pull_up_en` turns on during the second read.
- R4: If the upper bit is 1, only `pull_dn_en` turns on during the second read.
- R5: `pull_up_en` and `pull_dn_en` are never 1 in the same cycle.
- R6: When `done` is 1, both pull enables are 0 and `strap_code[0]` equals the pin level read under the opposing pull. Resulting codes: resistor to ground 01, short to ground 00, short to supply 11, resistor to supply 10.
- R7: Once `done` is 1 it stays 1. `strap_code` and `freq_sel` stay unchanged until reset, whatever `start` and the pin do.
- R8: While `done` is 0, `freq_sel` equals `DEFAULT_SEL` (default 0).
- R9: When `done` is 1, `freq_sel` maps the code as 01→0, 00→1, 11→2, 10→3. These are the slowest to fastest frequency choices.
- R10: With `AUTO_START`=0, the block stays idle with pulls off until `start` is sampled high. `done` then first reads 1 after exactly `SETTLE_HI_CYC + SETTLE_LO_CYC + 2*SYNC_STAGES + 3` rising edges, counting the edge that sampled `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Detection request; used only when `AUTO_START`=0 and the block is idle |
| pin_lvl | input | 1 | Asynchronous level from the strap pin input buffer |
| pull_up_en | output | 1 | Engages the weak pull toward supply |
| pull_dn_en | output | 1 | Engages the weak pull toward ground |
| done | output | 1 | Detection finished; results valid |
| strap_code | output | 2 | Upper bit = open read, lower bit = opposed read |
| freq_sel | output | 2 | Frequency-select index; default value until `done` |

## Verification
Two events can land in one cycle: a fresh `start` request and the final read that raises `done`. The bench drives a start pulse so that it is sampled on the very edge at which the manual-start instance finishes. It then expects `done` to stay high, both pulls to stay off and the already captured code to stay put. A pin condition that changes after completion is judged the same way, at the ports, over several following cycles.

// File: rtl/strap_pkg.sv
package strap_pkg;

    localparam int SEL_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE_HI,
        ST_GRAB_HI,
        ST_SETTLE_LO,
        ST_GRAB_LO,
        ST_DONE
    } strap_state_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } strap_code_t;

    typedef struct packed {
        logic pull_up;
        logic pull_dn;
    } strap_sw_t;

    // Map a strap code to the frequency index (slowest first).
    function automatic logic [SEL_W-1:0] code_to_sel(strap_code_t c);
        logic [SEL_W-1:0] s;
        case ({c.hi, c.lo})
            2'b01:   s = 2'd0;
            2'b00:   s = 2'd1;
            2'b11:   s = 2'd2;
            default: s = 2'd3;
        endcase
        return s;
    endfunction

    // Switch pattern for a given sequencer state and captured upper bit.
    function automatic strap_sw_t sw_for(strap_state_e st, logic hi);
        strap_sw_t sw;
        logic opposed;
        opposed    = (st == ST_SETTLE_LO) || (st == ST_GRAB_LO);
        sw.pull_up = opposed && !hi;
        sw.pull_dn = opposed && hi;
        return sw;
    endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/strap_settle_timer.sv
module strap_settle_timer #(
    parameter int HI_WAIT = 6,
    parameter int LO_WAIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic sel_lo,
    output logic expire
);
    localparam int MAX_WAIT = (HI_WAIT > LO_WAIT) ? HI_WAIT : LO_WAIT;
    localparam int CW       = (MAX_WAIT < 2) ? 1 : $clog2(MAX_WAIT);
    localparam logic [CW-1:0] HI_LAST = CW'(HI_WAIT - 1);
    localparam logic [CW-1:0] LO_LAST = CW'(LO_WAIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)   cnt_q <= '0;
        else if (!expire) cnt_q <= cnt_q + 1'b1;
    end

    assign expire = (cnt_q == (sel_lo ? LO_LAST : HI_LAST));
endmodule

// File: rtl/strap_seq.sv
module strap_seq
    import strap_pkg::*;
#(
    parameter bit AUTO_START = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        pin_s,
    input  logic        expire,
    output logic        tmr_clr,
    output logic        tmr_sel_lo,
    output strap_sw_t   sw,
    output strap_code_t code,
    output logic        done
);
    strap_state_e state_q, state_d;
    strap_code_t  code_q, code_d;
    strap_sw_t    sw_q;
    logic         done_q;

    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        unique case (state_q)
            ST_IDLE:      if (AUTO_START || start) state_d = ST_SETTLE_HI;
            ST_SETTLE_HI: if (expire) state_d = ST_GRAB_HI;
            ST_GRAB_HI: begin
                code_d.hi = pin_s;
                state_d   = ST_SETTLE_LO;
            end
            ST_SETTLE_LO: if (expire) state_d = ST_GRAB_LO;
            ST_GRAB_LO: begin
                code_d.lo = pin_s;
                state_d   = ST_DONE;
            end
            ST_DONE:      state_d = ST_DONE;
            default:      state_d = ST_IDLE;
        endcase
    end

    assign tmr_clr    = (state_q == ST_IDLE) || (state_q == ST_GRAB_HI);
    assign tmr_sel_lo = (state_q == ST_SETTLE_LO);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            code_q  <= '0;
            sw_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
            sw_q    <= sw_for(state_d, code_d.hi);
            done_q  <= (state_d == ST_DONE);
        end
    end

    assign sw   = sw_q;
    assign code = code_q;
    assign done = done_q;
endmodule

// File: rtl/strap_decoder.sv
module strap_decoder
    import strap_pkg::*;
#(
    parameter int              SETTLE_HI_CYC = 4,
    parameter int              SETTLE_LO_CYC = 6,
    parameter int              SYNC_STAGES   = 2,
    parameter bit              AUTO_START    = 1'b1,
    parameter logic [SEL_W-1:0] DEFAULT_SEL  = 2'd0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             pin_lvl,
    output logic             pull_up_en,
    output logic             pull_dn_en,
    output logic             done,
    output logic [1:0]       strap_code,
    output logic [SEL_W-1:0] freq_sel
);
    localparam int HI_WAIT = SETTLE_HI_CYC + SYNC_STAGES;
    localparam int LO_WAIT = SETTLE_LO_CYC + SYNC_STAGES;

    logic        pin_s;
    logic        expire;
    logic        tmr_clr;
    logic        tmr_sel_lo;
    strap_sw_t   sw;
    strap_code_t code;
    logic        msb_q;

    strap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_lvl),
        .q   (pin_s)
    );

    strap_settle_timer #(.HI_WAIT(HI_WAIT), .LO_WAIT(LO_WAIT)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clr    (tmr_clr),
        .sel_lo (tmr_sel_lo),
        .expire (expire)
    );

    strap_seq #(.AUTO_START(AUTO_START)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .pin_s      (pin_s),
        .expire     (expire),
        .tmr_clr    (tmr_clr),
        .tmr_sel_lo (tmr_sel_lo),
        .sw         (sw),
        .code       (code),
        .done       (done)
    );

    assign msb_q      = code.hi;
    assign pull_up_en = sw.pull_up;
    assign pull_dn_en = sw.pull_dn;
    assign strap_code = {code.hi, code.lo};
    assign freq_sel   = done ? code_to_sel(code) : DEFAULT_SEL;
endmodule

// File: rtl/strap_decoder_chk.sv
module strap_decoder_chk #(
    parameter logic [1:0] DEFAULT_SEL = 2'd0
) (
    input logic       clk,
    input logic       rst,
    input logic       pull_up_en,
    input logic       pull_dn_en,
    input logic       done,
    input logic [1:0] strap_code,
    input logic [1:0] freq_sel,
    input logic       msb_q
);
    logic [1:0] exp_sel;
    always_comb begin
        case (strap_code)
            2'b01:   exp_sel = 2'd0;
            2'b00:   exp_sel = 2'd1;
            2'b11:   exp_sel = 2'd2;
            default: exp_sel = 2'd3;
        endcase
    end

    p_up_needs_low_msb_r3: assert property (@(posedge clk) disable iff (rst)
        pull_up_en |-> !msb_q);
    p_dn_needs_high_msb_r4: assert property (@(posedge clk) disable iff (rst)
        pull_dn_en |-> msb_q);
    p_pulls_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
        !(pull_up_en && pull_dn_en));
    p_pulls_off_when_done_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> (!pull_up_en && !pull_dn_en));
    p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> done);
    p_result_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> ($stable(strap_code) && $stable(freq_sel)));
    p_default_until_done_r8: assert property (@(posedge clk) disable iff (rst)
        !done |-> (freq_sel == DEFAULT_SEL));
    p_sel_mapping_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (freq_sel == exp_sel));
endmodule

bind strap_decoder strap_decoder_chk #(.DEFAULT_SEL(DEFAULT_SEL)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pull_up_en (pull_up_en),
    .pull_dn_en (pull_dn_en),
    .done       (done),
    .strap_code (strap_code),
    .freq_sel   (freq_sel),
    .msb_q      (msb_q)
);

// File: tb/strap_decoder_tb.sv
`timescale 1ns/1ps
module strap_decoder_tb;
    // Pin conditions: 0 resistor to ground, 1 short to ground,
    // 2 short to supply, 3 resistor to supply.
    localparam int A_HI = 4, A_LO = 6, M_HI = 1, M_LO = 1, SYNC = 2;
    localparam int LAT_A = A_HI + A_LO + 2*SYNC + 3;
    localparam int LAT_M = M_HI + M_LO + 2*SYNC + 3;
    localparam int OPEN_A = A_HI + SYNC + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_a = 1'b0, start_m = 1'b0;
    int   cond_a = 0, cond_m = 0;
    logic pu_a, pd_a, done_a, pu_m, pd_m, done_m;
    logic [1:0] code_a, sel_a, code_m, sel_m;
    logic pin_a, pin_m;
    int   n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    function automatic logic pin_model(int c, logic pu, logic pd);
        case (c)
            0: return pu;
            1: return 1'b0;
            2: return 1'b1;
            default: return !pd;
        endcase
    endfunction

    function automatic logic [1:0] exp_code(int c);
        case (c)
            0: return 2'b01;
            1: return 2'b00;
            2: return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    assign pin_a = pin_model(cond_a, pu_a, pd_a);
    assign pin_m = pin_model(cond_m, pu_m, pd_m);

    strap_decoder #(.SETTLE_HI_CYC(A_HI), .SETTLE_LO_CYC(A_LO), .SYNC_STAGES(SYNC),
                    .AUTO_START(1'b1), .DEFAULT_SEL(2'd0)) u_dut (
        .clk(clk), .rst(rst), .start(start_a), .pin_lvl(pin_a),
        .pull_up_en(pu_a), .pull_dn_en(pd_a), .done(done_a),
        .strap_code(code_a), .freq_sel(sel_a));

    strap_decoder #(.SETTLE_HI_CYC(M_HI), .SETTLE_LO_CYC(M_LO), .SYNC_STAGES(SYNC),
                    .AUTO_START(1'b0), .DEFAULT_SEL(2'd0)) u_dut_man (
        .clk(clk), .rst(rst), .start(start_m), .pin_lvl(pin_m),
        .pull_up_en(pu_m), .pull_dn_en(pd_m), .done(done_m),
        .strap_code(code_m), .freq_sel(sel_m));

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 done in reset", done_a, 0);
        check("R1 pulls in reset", {pu_a, pd_a}, 0);
        check("R1 code in reset", code_a, 0);
        check("R1 sel in reset", sel_a, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 done first cycle", done_a, 0);
        check("R1 pulls first cycle", {pu_a, pd_a}, 0);
    endtask

    task automatic t_strap(int c);
        int  lat = 0;
        bit  open_bad = 0, both = 0, saw_pu = 0, saw_pd = 0, def_bad = 0;
        cond_a = c;
        do_reset();
        for (int i = 1; i <= 60; i++) begin
            @(negedge clk);
            if (pu_a && pd_a) both = 1;
            if (i <= OPEN_A && (pu_a || pd_a)) open_bad = 1;
            if (pu_a) saw_pu = 1;
            if (pd_a) saw_pd = 1;
            if (done_a) begin lat = i; break; end
            if (sel_a != 2'd0) def_bad = 1;
        end
        check("R2 latency", lat, LAT_A);
        check("R3 pulls open during first read", open_bad, 0);
        check("R5 pulls exclusive", both, 0);
        check("R8 default sel before done", def_bad, 0);
        if (exp_code(c) >= 2) begin
            check("R4 pull-down used", saw_pd, 1);
            check("R4 pull-up unused", saw_pu, 0);
        end else begin
            check("R3 pull-up used", saw_pu, 1);
            check("R3 pull-down unused", saw_pd, 0);
        end
        check("R6 code", code_a, exp_code(c));
        check("R6 pulls off at done", {pu_a, pd_a}, 0);
        check("R9 sel", sel_a, c);
    endtask

    task automatic t_hold_after_done();
        t_strap(3);
        cond_a = 1;
        @(negedge clk) start_a = 1'b1;
        @(negedge clk) start_a = 1'b0;
        repeat (8) @(negedge clk);
        check("R7 done held", done_a, 1);
        check("R7 code held", code_a, 2'b10);
        check("R7 sel held", sel_a, 3);
        check("R7 pulls stay off", {pu_a, pd_a}, 0);
    endtask

    task automatic t_manual_idle();
        cond_m = 2;
        do_reset();
        repeat (30) @(negedge clk);
        check("R10 idle without start", done_m, 0);
        check("R10 pulls off when idle", {pu_m, pd_m}, 0);
        check("R8 default sel idle", sel_m, 0);
    endtask

    task automatic t_start_at_done();
        cond_m = 0;
        do_reset();
        repeat (4) @(negedge clk);
        start_m = 1'b1;
        @(negedge clk) start_m = 1'b0;
        // one edge consumed; done rises on edge LAT_M
        repeat (LAT_M - 3) @(negedge clk);
        check("R10 not done early", done_m, 0);
        @(negedge clk);
        check("R10 not done one before", done_m, 0);
        start_m = 1'b1;
        @(negedge clk) start_m = 1'b0;
        check("R10 latency from start", done_m, 1);
        check("R6 manual code", code_m, 2'b01);
        check("R9 manual sel", sel_m, 0);
        cond_m = 3;
        repeat (6) @(negedge clk);
        check("R7 start at done ignored", done_m, 1);
        check("R7 manual code held", code_m, 2'b01);
        check("R7 manual pulls off", {pu_m, pd_m}, 0);
    endtask

    initial begin
        t_reset_state();
        t_strap(0);
        t_strap(1);
        t_strap(2);
        t_strap(3);
        t_hold_after_done();
        t_manual_idle();
        t_start_at_done();
        summary();
        $finish;
    end

    initial begin
        repeat (100_000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end
endmodule